// File: doc/BRIEF.md
# Rename History Log with Rollback and Retirement

This block keeps an ordered log of the register renames made by an out-of-order core, so that speculative work can be undone and finished work can release registers. Each time rename assigns a fresh physical register to an architectural destination, one log entry is pushed at the young end. The entry records the instruction sequence number, the architectural register, the fresh physical register and the physical register it displaced. An instruction that writes no register pushes a marker entry that carries only its sequence number. An instruction that writes several registers pushes one entry per destination, all with the same sequence number.

A squash request carries the sequence number of the last surviving instruction. The log is then unwound from the young end, one entry per cycle. Each real entry drives a write to the external mapping table that restores the displaced register, and returns the fresh register to the external free list. A commit request carries the sequence number of a finished instruction. The log is then drained from the old end, one entry per cycle, and each real entry returns its displaced register to the free list. While a walk runs the block reports busy and refuses new pushes and requests.

Top module: `rename_log`

## Requirements
- R1: After reset the log is empty, `busy` is low, `push_ready` is high and neither `restore_valid` nor `free_valid` is asserted.
- R2: A push with `push_valid` and `push_ready` both high appends one entry. `push_ready` is low while the log holds DEPTH entries, and a push offered then is dropped.
- R3: A push with `push_has_dst` low stores a marker entry. Removing a marker entry, by squash or by commit, asserts neither `restore_valid` nor `free_valid`.
- R4: A squash with sequence S removes entries from the young end, one per cycle, while the youngest entry's sequence is greater than S, compared as unsigned. In the cycle a real entry is removed, `restore_valid` is high with that entry's architectural register and displaced register, and `free_valid` is high with its fresh register.
- R5: A commit with sequence N removes entries from the old end, one per cycle, while the oldest entry's sequence is at most N. Each real entry raises `free_valid` with its displaced register and leaves `restore_valid` low.
- R6: A commit whose sequence is smaller than the oldest entry's sequence removes nothing and frees nothing.
- R7: A squash on an empty log removes nothing and frees nothing, and `busy` is high for exactly one cycle.
- R8: A request accepted while idle raises `busy` in the next cycle. `busy` stays high for the number of removed entries plus one cycle. Requests made while `busy` is high are ignored, and `push_ready` is low while `busy` or any request is high.
- R9: When a squash and a commit are requested in the same idle cycle, only the squash is carried out.
- R10: The entries pushed for one instruction with several destinations share its sequence number and are all removed by the same squash or commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Offer a new log entry |
| push_has_dst | input | 1 | 1: real rename, 0: marker entry |
| push_seq | input | SEQ_W | Sequence number of the pushing instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Freshly allocated physical register |
| push_old_preg | input | PREG_W | Physical register it displaces |
| push_ready | output | 1 | Push accepted this cycle if offered |
| squash_req | input | 1 | Start a rollback walk |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| commit_req | input | 1 | Start a retirement walk |
| commit_seq | input | SEQ_W | Finished sequence number |
| busy | output | 1 | A walk is in progress |
| restore_valid | output | 1 | Write the mapping table this cycle |
| restore_areg | output | AREG_W | Mapping table index to restore |
| restore_preg | output | PREG_W | Physical register to put back in the mapping |
| free_valid | output | 1 | Return a register to the free list this cycle |
| free_preg | output | PREG_W | Register being returned |

## Verification
The bench sweeps the squash point across every position of a full log, with markers mixed among real entries. This catches an off-by-one boundary, which would remove one entry too many or keep one too few, and a swapped register field, which would free the displaced register on a rollback. Commits below the oldest entry and squashes of an empty log are also run. A design that got these wrong would free registers it does not own, or stay busy for the wrong number of cycles. The bench offers a push while the log is full, raises a squash and a commit in the same cycle, and pokes a commit during a walk. Each of these must leave the log contents unchanged, and the bench confirms this by draining the log afterwards.

// File: rtl/rlog_pkg.sv
package rlog_pkg;

    parameter int SEQ_W  = 8;
    parameter int AREG_W = 4;
    parameter int PREG_W = 6;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [PREG_W-1:0] preg_t;

    typedef struct packed {
        seq_t  seq;
        areg_t areg;
        preg_t fresh;
        preg_t displaced;
        logic  marker;
    } rlog_entry_t;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_UNDO,
        WALK_RETIRE
    } walk_e;

    // Unsigned age comparison: a is younger than b.
    function automatic logic younger(input seq_t a, input seq_t b);
        return a > b;
    endfunction

endpackage

// File: rtl/rlog_store.sv
module rlog_store
    import rlog_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  rlog_entry_t       wr_data,
    input  logic [PTR_W-1:0]  old_idx,
    input  logic [PTR_W-1:0]  young_idx,
    output rlog_entry_t       old_entry,
    output rlog_entry_t       young_entry
);

    rlog_entry_t slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PTR_W'(g)) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign old_entry   = slot[old_idx];
    assign young_entry = slot[young_idx];

endmodule

// File: rtl/rlog_ptrs.sv
module rlog_ptrs #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_fire,
    input  logic             pop_old,
    input  logic             pop_young,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] young_idx,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else if (push_fire) begin
            tail <= tail + 1'b1;
            occ  <= occ + 1'b1;
        end else if (pop_old) begin
            head <= head + 1'b1;
            occ  <= occ - 1'b1;
        end else if (pop_young) begin
            tail <= tail - 1'b1;
            occ  <= occ - 1'b1;
        end
    end

    assign young_idx = tail - 1'b1;
    assign full      = (occ == OCC_W'(DEPTH));
    assign empty     = (occ == '0);

endmodule

// File: rtl/rlog_walk.sv
module rlog_walk
    import rlog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        squash_req,
    input  seq_t        squash_seq,
    input  logic        commit_req,
    input  seq_t        commit_seq,
    input  logic        empty,
    input  rlog_entry_t old_entry,
    input  rlog_entry_t young_entry,
    output logic        busy,
    output logic        pop_old,
    output logic        pop_young,
    output logic        restore_valid,
    output areg_t       restore_areg,
    output preg_t       restore_preg,
    output logic        free_valid,
    output preg_t       free_preg
);

    walk_e state;
    seq_t  limit;

    always_comb begin
        pop_young = (state == WALK_UNDO)   && !empty && younger(young_entry.seq, limit);
        pop_old   = (state == WALK_RETIRE) && !empty && !younger(old_entry.seq, limit);
        busy      = (state != WALK_IDLE);

        restore_valid = pop_young && !young_entry.marker;
        restore_areg  = young_entry.areg;
        restore_preg  = young_entry.displaced;
        free_valid    = (pop_young && !young_entry.marker) ||
                        (pop_old && !old_entry.marker);
        free_preg     = pop_young ? young_entry.fresh : old_entry.displaced;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WALK_IDLE;
            limit <= '0;
        end else begin
            unique case (state)
                WALK_IDLE: begin
                    if (squash_req) begin
                        state <= WALK_UNDO;
                        limit <= squash_seq;
                    end else if (commit_req) begin
                        state <= WALK_RETIRE;
                        limit <= commit_seq;
                    end
                end
                WALK_UNDO:   if (!pop_young) state <= WALK_IDLE;
                WALK_RETIRE: if (!pop_old)   state <= WALK_IDLE;
                default:     state <= WALK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rename_log.sv
module rename_log
    import rlog_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic              push_has_dst,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new_preg,
    input  logic [PREG_W-1:0] push_old_preg,
    output logic              push_ready,
    input  logic              squash_req,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_req,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              busy,
    output logic              restore_valid,
    output logic [AREG_W-1:0] restore_areg,
    output logic [PREG_W-1:0] restore_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg
);

    logic [PTR_W-1:0] head, tail, young_idx;
    logic [OCC_W-1:0] occ;
    logic             full, empty, push_fire, pop_old, pop_young;
    rlog_entry_t      new_entry, old_entry, young_entry;

    assign push_ready = !full && !busy && !squash_req && !commit_req;
    assign push_fire  = push_valid && push_ready;

    always_comb begin
        new_entry.seq       = push_seq;
        new_entry.marker    = !push_has_dst;
        new_entry.areg      = push_has_dst ? push_areg     : '0;
        new_entry.fresh     = push_has_dst ? push_new_preg : '0;
        new_entry.displaced = push_has_dst ? push_old_preg : '0;
    end

    rlog_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .push_fire(push_fire), .pop_old(pop_old),
        .pop_young(pop_young), .head(head), .tail(tail), .young_idx(young_idx),
        .occ(occ), .full(full), .empty(empty)
    );

    rlog_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(push_fire), .wr_idx(tail), .wr_data(new_entry),
        .old_idx(head), .young_idx(young_idx),
        .old_entry(old_entry), .young_entry(young_entry)
    );

    rlog_walk u_walk (
        .clk(clk), .rst(rst), .squash_req(squash_req), .squash_seq(squash_seq),
        .commit_req(commit_req), .commit_seq(commit_seq), .empty(empty),
        .old_entry(old_entry), .young_entry(young_entry), .busy(busy),
        .pop_old(pop_old), .pop_young(pop_young),
        .restore_valid(restore_valid), .restore_areg(restore_areg),
        .restore_preg(restore_preg), .free_valid(free_valid), .free_preg(free_preg)
    );

endmodule

// File: rtl/rlog_checker.sv
module rlog_checker #(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             push_valid,
    input logic             push_ready,
    input logic             squash_req,
    input logic             commit_req,
    input logic             busy,
    input logic             restore_valid,
    input logic             free_valid,
    input logic [OCC_W-1:0] occ
);

    p_restore_with_free_r4: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> free_valid);

    p_outputs_in_walk_r8: assert property (@(posedge clk) disable iff (rst)
        (restore_valid || free_valid) |-> busy);

    p_walk_starts_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && (squash_req || commit_req)) |=> busy);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (occ == OCC_W'(DEPTH)) |-> !push_ready);

    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready) |=> (occ == $past(occ) + 1'b1));

endmodule

bind rename_log rlog_checker #(.DEPTH(DEPTH)) u_rlog_checker (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .squash_req(squash_req), .commit_req(commit_req), .busy(busy),
    .restore_valid(restore_valid), .free_valid(free_valid), .occ(occ)
);

// File: tb/test_rename_log.sv
module test_rename_log;
    import rlog_pkg::*;

    localparam int DEPTH = 8;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  push_valid = 1'b0, push_has_dst = 1'b0;
    seq_t  push_seq = '0;
    areg_t push_areg = '0;
    preg_t push_new_preg = '0, push_old_preg = '0;
    logic  push_ready;
    logic  squash_req = 1'b0, commit_req = 1'b0;
    seq_t  squash_seq = '0, commit_seq = '0;
    logic  busy, restore_valid, free_valid;
    areg_t restore_areg;
    preg_t restore_preg, free_preg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    rlog_entry_t mdl [$];

    always #5 clk = ~clk;

    rename_log #(.DEPTH(DEPTH)) i_rename_log (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_has_dst(push_has_dst),
        .push_seq(push_seq), .push_areg(push_areg), .push_new_preg(push_new_preg),
        .push_old_preg(push_old_preg), .push_ready(push_ready),
        .squash_req(squash_req), .squash_seq(squash_seq),
        .commit_req(commit_req), .commit_seq(commit_seq), .busy(busy),
        .restore_valid(restore_valid), .restore_areg(restore_areg),
        .restore_preg(restore_preg), .free_valid(free_valid), .free_preg(free_preg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int seq, input bit has, input int areg,
                        input int np, input int op);
        rlog_entry_t e;
        bit exp_ready;
        @(negedge clk);
        push_valid = 1'b1; push_has_dst = has; push_seq = seq_t'(seq);
        push_areg = areg_t'(areg); push_new_preg = preg_t'(np); push_old_preg = preg_t'(op);
        #1;
        exp_ready = (mdl.size() < DEPTH);
        chk(push_ready == exp_ready, "R2", "push_ready", int'(push_ready), int'(exp_ready));
        @(negedge clk);
        push_valid = 1'b0;
        if (exp_ready) begin
            e.seq = seq_t'(seq); e.marker = !has;
            e.areg = has ? areg_t'(areg) : '0;
            e.fresh = has ? preg_t'(np) : '0;
            e.displaced = has ? preg_t'(op) : '0;
            mdl.push_back(e);
        end
    endtask

    // Runs one walk. sq selects squash (R4/R7/R9), otherwise commit (R5/R6).
    task automatic walk(input bit sq, input bit cm, input int s_sq, input int s_cm,
                        input bit poke, input string req);
        rlog_entry_t exp_q [$];
        int n, i;
        bit is_undo;
        is_undo = sq;
        if (is_undo) begin
            while (mdl.size() > 0 && mdl[mdl.size()-1].seq > seq_t'(s_sq))
                exp_q.push_back(mdl.pop_back());
        end else begin
            while (mdl.size() > 0 && mdl[0].seq <= seq_t'(s_cm))
                exp_q.push_back(mdl.pop_front());
        end
        n = exp_q.size();
        @(negedge clk);
        squash_req = sq; commit_req = cm;
        squash_seq = seq_t'(s_sq); commit_seq = seq_t'(s_cm);
        #1;
        chk(push_ready == 1'b0, "R8", "push_ready with request", int'(push_ready), 0);
        @(negedge clk);
        squash_req = 1'b0; commit_req = 1'b0;
        if (poke) begin
            commit_req = 1'b1; commit_seq = '1;
        end
        i = 0;
        while (busy && i < 64) begin
            if (i < n) begin
                if (exp_q[i].marker) begin
                    chk(!restore_valid && !free_valid, "R3", "marker outputs",
                        int'({restore_valid, free_valid}), 0);
                end else if (is_undo) begin
                    chk(restore_valid, req, "restore_valid", int'(restore_valid), 1);
                    chk(restore_areg == exp_q[i].areg, req, "restore_areg",
                        int'(restore_areg), int'(exp_q[i].areg));
                    chk(restore_preg == exp_q[i].displaced, req, "restore_preg",
                        int'(restore_preg), int'(exp_q[i].displaced));
                    chk(free_valid && free_preg == exp_q[i].fresh, req, "free fresh",
                        int'(free_preg), int'(exp_q[i].fresh));
                end else begin
                    chk(!restore_valid, req, "restore on commit", int'(restore_valid), 0);
                    chk(free_valid && free_preg == exp_q[i].displaced, req, "free displaced",
                        int'(free_preg), int'(exp_q[i].displaced));
                end
            end else begin
                chk(!restore_valid && !free_valid, req, "idle walk cycle",
                    int'({restore_valid, free_valid}), 0);
            end
            chk(!push_ready, "R8", "push_ready while busy", int'(push_ready), 0);
            i++;
            @(negedge clk);
            commit_req = 1'b0;
        end
        chk(i == n + 1, "R8", "busy cycles", i, n + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && push_ready && !restore_valid && !free_valid, "R1", "reset outputs",
            int'({busy, push_ready, restore_valid, free_valid}), 4);

        // R7: squash on empty
        walk(1'b1, 1'b0, 0, 0, 1'b0, "R7");

        // R10: multi-destination instruction, R3 marker
        push(1, 1'b1, 1, 10, 1);
        push(2, 1'b0, 0, 0, 0);
        push(3, 1'b1, 2, 11, 2);
        push(3, 1'b1, 3, 12, 3);
        push(4, 1'b1, 4, 13, 4);
        // R6: commit older than the oldest entry is ignored
        walk(1'b0, 1'b1, 0, 0, 1'b0, "R6");
        // R4 with R10: squash back to seq 2 removes 4, 3, 3
        walk(1'b1, 1'b0, 2, 0, 1'b0, "R10");
        // R5: commit through seq 2
        walk(1'b0, 1'b1, 0, 2, 1'b0, "R5");
        chk(mdl.size() == 0, "R5", "model drained", mdl.size(), 0);

        // R2: fill, then an extra push is dropped
        for (int i = 0; i < DEPTH; i++) push(10 + i, 1'b1, i, 20 + i, 40 + i);
        push(99, 1'b1, 5, 63, 62);
        // R9: squash and commit together; R8: commit poked while busy is ignored
        walk(1'b1, 1'b1, 13, 20, 1'b1, "R9");
        walk(1'b0, 1'b1, 0, 255, 1'b0, "R5");
        walk(1'b1, 1'b0, 0, 0, 1'b0, "R7");

        // R4 sweep: every squash point across a full log with markers mixed in
        for (int k = 0; k <= DEPTH; k++) begin
            for (int i = 0; i < DEPTH; i++)
                push(10 + 2 * i, (i % 3) != 1, (i + k) % 16, (16 + i + k) % 64, (i * 5 + k) % 64);
            walk(1'b1, 1'b0, 9 + 2 * k, 0, 1'b0, "R4");
            walk(1'b0, 1'b1, 0, 255, 1'b0, "R5");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule